// File: doc/BRIEF.md
# Vector Operand Read-Port Allocator

This block sits between the vector scheduler and the register-file read muxes. Every cycle it sees up to four operations, one per request slot, with slot 0 the oldest. Each operation names the execution pipe it is bound for, its operation class and its masking mode. From these it works out how many register inputs the operation needs. It then decides which operations may read their operands this cycle.

Each of the four pipes owns two read ports. A pool of two further ports can be lent to any pipe. An operation first fills its pipe's own ports. Any inputs left over come from the pool, and it takes the lowest-numbered free pool ports. An operation that cannot be fully served is stalled, and so are all younger operations bound for the same pipe. Operations bound for other pipes go on being considered.

The decision is registered. The grant, stall and pool-port select vectors appear one clock after the requests are presented. The scheduler replays stalled operations in a later cycle. The pool-port selects drive the read-mux controls of the shared ports directly.

Top module: `operand_port_alloc`

## Requirements
- R1: While reset is asserted, and after it is released with no valid request, all grant, stall and pool-select outputs are zero; asserting reset clears them at once.
- R2: The decision for the requests present at a rising clock edge appears on the outputs after that edge and holds for one cycle. A slot whose valid bit is low is neither granted nor stalled.
- R3: Input demand is set by the 2-bit class and the 2-bit mask code. Class 0 (move) needs 1 input, class 1 (add) needs 2, and class 2 (fused multiply-add) and class 3 (ternary logic) need 3. Mask code 2 (merge) adds one input. Codes 0 (unmasked), 1 (zero-masking) and 3 (treated as unmasked) add none, so the mask itself costs no port.
- R4: Slots are served oldest first. Once a slot bound for a pipe stalls, every younger slot bound for that pipe stalls in the same cycle.
- R5: A granted operation takes as many of its pipe's two own ports as are still free, up to its demand. Operations bound for the same pipe share those two ports. Only the remainder comes from the pool.
- R6: The remainder is served by the lowest-numbered free pool ports. Bit k of a slot's 2-bit pool-select field marks pool port k, and no pool port is given to two slots in one cycle.
- R7: A slot whose remainder exceeds the free pool ports is stalled, takes no port, and has an all-zero pool-select field. Its stall bit is high exactly when its valid bit is high and it is not granted.
- R8: A stall on one pipe does not block younger slots bound for other pipes. Those slots may still use the pool ports that the stalled slot did not take.
- R9: Two adds and two fused multiply-adds on four different pipes (10 inputs) are all granted in one cycle. Four ternary operations (12 inputs) are not: the two oldest are granted and the two younger are stalled.
- R10: An add and a fused multiply-add on two pipes, both merge-masked (3 and 4 inputs), cannot both be granted in one cycle, while the same pair zero-masked can.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 4 | Per-slot request valid, slot 0 oldest |
| req_pipe | input | 8 | Per-slot target pipe, 2 bits per slot |
| req_class | input | 8 | Per-slot operation class, 2 bits per slot |
| req_mask | input | 8 | Per-slot mask code, 2 bits per slot |
| gnt | output | 4 | Per-slot grant, registered |
| stall | output | 4 | Per-slot stall, registered |
| gnt_pool | output | 8 | Per-slot pool-port select, 2 bits per slot, registered |

## Verification
The bench uses the default sizes: four slots, four pipes, two own ports per pipe and two pool ports. With these sizes both capacity limits are easy to reach. Three-input operations can exhaust the pool after two slots. Several slots can be bound for one pipe, so the own ports of that pipe run out and the per-pipe age ordering comes into play. With only two pool ports, every mix of grants, stalls and pool selections across the four slots can be reached by random requests. A behavioural reference model in the bench is compared with the outputs on every cycle.

// File: rtl/opa_pkg.sv
package opa_pkg;
  typedef enum logic [1:0] {
    CLS_MOVE = 2'd0,
    CLS_ADD  = 2'd1,
    CLS_FMA  = 2'd2,
    CLS_TERN = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    MSK_NONE  = 2'd0,
    MSK_ZERO  = 2'd1,
    MSK_MERGE = 2'd2,
    MSK_RSVD  = 2'd3
  } mask_mode_e;

  // width of an operand-demand count (max 4)
  localparam int DEM_W = 3;
  // width of internal allocation arithmetic
  localparam int ARW = 8;
endpackage

// File: rtl/opa_rst_sync.sv
module opa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/opa_demand.sv
module opa_demand
  import opa_pkg::*;
(
  input  logic [1:0]       cls_i,
  input  logic [1:0]       msk_i,
  output logic [DEM_W-1:0] need_o
);
  logic [DEM_W-1:0] base;
  logic [DEM_W-1:0] extra;

  always_comb begin
    unique case (op_class_e'(cls_i))
      CLS_MOVE: base = DEM_W'(1);
      CLS_ADD:  base = DEM_W'(2);
      CLS_FMA:  base = DEM_W'(3);
      default:  base = DEM_W'(3);
    endcase
    // merge-masking reads the old destination as an extra operand
    extra  = (mask_mode_e'(msk_i) == MSK_MERGE) ? DEM_W'(1) : DEM_W'(0);
    need_o = base + extra;
  end
endmodule

// File: rtl/opa_stage.sv
module opa_stage
  import opa_pkg::*;
#(
  parameter int NUM_PIPES  = 4,
  parameter int DED_PORTS  = 2,
  parameter int NUM_SHARED = 2,
  parameter int PW         = 2,
  parameter int CW         = 2
) (
  input  logic                               valid_i,
  input  logic [PW-1:0]                      pipe_i,
  input  logic [DEM_W-1:0]                   need_i,
  input  logic [NUM_PIPES-1:0][CW-1:0]       used_i,
  input  logic [NUM_SHARED-1:0]              free_i,
  input  logic [NUM_PIPES-1:0]               blk_i,
  output logic [NUM_PIPES-1:0][CW-1:0]       used_o,
  output logic [NUM_SHARED-1:0]              free_o,
  output logic [NUM_PIPES-1:0]               blk_o,
  output logic                               grant_o,
  output logic [NUM_SHARED-1:0]              sel_o
);
  logic [ARW-1:0] ded_left;
  logic [ARW-1:0] need_w;
  logic [ARW-1:0] take_ded;
  logic [ARW-1:0] rem;
  logic [ARW-1:0] free_cnt;
  logic [ARW-1:0] picked;
  logic [NUM_SHARED-1:0] pick_mask;
  logic fits;

  always_comb begin
    need_w   = ARW'(need_i);
    ded_left = ARW'(DED_PORTS) - ARW'(used_i[pipe_i]);
    take_ded = (need_w < ded_left) ? need_w : ded_left;
    rem      = need_w - take_ded;
    free_cnt = ARW'($countones(free_i));
    fits     = valid_i && !blk_i[pipe_i] && (rem <= free_cnt);

    // lowest-numbered free pool ports first
    pick_mask = '0;
    picked    = '0;
    for (int k = 0; k < NUM_SHARED; k++) begin
      if (free_i[k] && (picked < rem)) begin
        pick_mask[k] = 1'b1;
        picked       = picked + ARW'(1);
      end
    end

    grant_o = fits;
    sel_o   = fits ? pick_mask : '0;

    used_o = used_i;
    if (fits) used_o[pipe_i] = used_i[pipe_i] + CW'(take_ded);

    free_o = free_i & ~sel_o;

    blk_o = blk_i;
    if (valid_i && !fits) blk_o[pipe_i] = 1'b1;
  end
endmodule

// File: rtl/operand_port_alloc.sv
module operand_port_alloc
  import opa_pkg::*;
#(
  parameter int NUM_OPS    = 4,
  parameter int NUM_PIPES  = 4,
  parameter int DED_PORTS  = 2,
  parameter int NUM_SHARED = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [NUM_OPS-1:0]                        req_valid,
  input  logic [NUM_OPS*((NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1)-1:0] req_pipe,
  input  logic [NUM_OPS*2-1:0]                      req_class,
  input  logic [NUM_OPS*2-1:0]                      req_mask,
  output logic [NUM_OPS-1:0]                        gnt,
  output logic [NUM_OPS-1:0]                        stall,
  output logic [NUM_OPS*NUM_SHARED-1:0]             gnt_pool
);
  localparam int PW = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1;
  localparam int CW = $clog2(DED_PORTS + 1);

  logic rst_sync_n;

  logic [NUM_OPS:0][NUM_PIPES-1:0][CW-1:0] used_c;
  logic [NUM_OPS:0][NUM_SHARED-1:0]        free_c;
  logic [NUM_OPS:0][NUM_PIPES-1:0]         blk_c;

  logic [NUM_OPS-1:0]                      gnt_d;
  logic [NUM_OPS-1:0][NUM_SHARED-1:0]      sel_d;
  logic [NUM_OPS-1:0][PW-1:0]              pipe_w;
  logic [NUM_OPS-1:0][DEM_W-1:0]           need_w;

  logic [NUM_OPS-1:0]                      gnt_n,  gnt_q;
  logic [NUM_OPS-1:0]                      stall_n, stall_q;
  logic [NUM_OPS*NUM_SHARED-1:0]           pool_n, pool_q;
  logic                                    upd_en;

  opa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign used_c[0] = '0;
  assign free_c[0] = '1;
  assign blk_c[0]  = '0;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_slot
    assign pipe_w[i] = req_pipe[i*PW +: PW];

    opa_demand u_dem (
      .cls_i  (req_class[i*2 +: 2]),
      .msk_i  (req_mask[i*2 +: 2]),
      .need_o (need_w[i])
    );

    opa_stage #(
      .NUM_PIPES  (NUM_PIPES),
      .DED_PORTS  (DED_PORTS),
      .NUM_SHARED (NUM_SHARED),
      .PW         (PW),
      .CW         (CW)
    ) u_stage (
      .valid_i (req_valid[i]),
      .pipe_i  (pipe_w[i]),
      .need_i  (need_w[i]),
      .used_i  (used_c[i]),
      .free_i  (free_c[i]),
      .blk_i   (blk_c[i]),
      .used_o  (used_c[i+1]),
      .free_o  (free_c[i+1]),
      .blk_o   (blk_c[i+1]),
      .grant_o (gnt_d[i]),
      .sel_o   (sel_d[i])
    );

    // R6: a slot only ever draws pool ports left free by older slots
    assert_pool_from_free_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sel_d[i] & ~free_c[i]) == '0);

    // R4: a pipe blocked by an older slot admits no younger slot
    assert_pipe_age_order_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      blk_c[i][pipe_w[i]] |-> !gnt_d[i]);

    // R2: a registered grant stems from a valid request one edge earlier
    assert_grant_from_valid_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      gnt_q[i] |-> $past(req_valid[i]));

    // R7: an ungranted slot carries no pool select
    assert_idle_no_pool_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !gnt_q[i] |-> (pool_q[i*NUM_SHARED +: NUM_SHARED] == '0));

    // R7: grant and stall never coincide
    assert_grant_stall_excl_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !(gnt_q[i] && stall_q[i]));
  end

  // next-state
  always_comb begin
    upd_en  = 1'b1;
    gnt_n   = gnt_d;
    stall_n = req_valid & ~gnt_d;
    for (int i = 0; i < NUM_OPS; i++) begin
      pool_n[i*NUM_SHARED +: NUM_SHARED] = sel_d[i];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gnt_q   <= '0;
      stall_q <= '0;
      pool_q  <= '0;
    end else if (upd_en) begin
      gnt_q   <= gnt_n;
      stall_q <= stall_n;
      pool_q  <= pool_n;
    end
  end

  assign gnt      = gnt_q;
  assign stall    = stall_q;
  assign gnt_pool = pool_q;
endmodule

// File: tb/operand_port_alloc_test.sv
module operand_port_alloc_test;
  logic       clk;
  logic       rst_n;
  logic [3:0] req_valid;
  logic [7:0] req_pipe;
  logic [7:0] req_class;
  logic [7:0] req_mask;
  logic [3:0] gnt;
  logic [3:0] stall;
  logic [7:0] gnt_pool;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  operand_port_alloc uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_pipe  (req_pipe),
    .req_class (req_class),
    .req_mask  (req_mask),
    .gnt       (gnt),
    .stall     (stall),
    .gnt_pool  (gnt_pool)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference: walk slots oldest first
  task automatic model(input logic [3:0] v, input logic [7:0] p, input logic [7:0] c,
                       input logic [7:0] m, output logic [3:0] eg, output logic [3:0] es,
                       output logic [7:0] ep);
    int ded_used[4];
    bit pool_free[2];
    bit blocked[4];
    eg = '0; es = '0; ep = '0;
    for (int q = 0; q < 4; q++) begin ded_used[q] = 0; blocked[q] = 0; end
    pool_free[0] = 1; pool_free[1] = 1;
    for (int i = 0; i < 4; i++) begin
      int need, pp, left, td, r, nfree, got;
      if (!v[i]) continue;
      pp   = int'(p[i*2 +: 2]);
      need = (c[i*2 +: 2] == 2'd0) ? 1 : (c[i*2 +: 2] == 2'd1) ? 2 : 3;
      if (m[i*2 +: 2] == 2'd2) need++;
      left = 2 - ded_used[pp];
      td   = (need < left) ? need : left;
      r    = need - td;
      nfree = int'(pool_free[0]) + int'(pool_free[1]);
      if (blocked[pp] || r > nfree) begin
        blocked[pp] = 1;
        es[i] = 1'b1;
      end else begin
        eg[i] = 1'b1;
        ded_used[pp] += td;
        got = 0;
        for (int k = 0; k < 2; k++) begin
          if (pool_free[k] && got < r) begin
            pool_free[k] = 0;
            ep[i*2 + k] = 1'b1;
            got++;
          end
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic step(input logic [3:0] v, input logic [7:0] p, input logic [7:0] c,
                      input logic [7:0] m, input string tag);
    logic [3:0] eg, es;
    logic [7:0] ep;
    req_valid = v; req_pipe = p; req_class = c; req_mask = m;
    model(v, p, c, m, eg, es, ep);
    @(negedge clk);
    check(tag, {gnt, stall, gnt_pool}, {eg, es, ep}, "gnt/stall/pool vs model");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_pipe = '0; req_class = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    check("R1", {gnt, stall, gnt_pool}, 16'h0, "outputs in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {gnt, stall, gnt_pool}, 16'h0, "outputs after release, idle");

    // R2: invalid slots with non-zero fields
    step(4'b0000, 8'hE4, 8'hFF, 8'hAA, "R2");
    check("R2", {gnt, stall}, 8'h0, "invalid slots idle");

    // R9: add,add,fma,fma on pipes 0..3
    step(4'b1111, 8'b11_10_01_00, 8'b10_10_01_01, 8'h00, "R9");
    check("R9", gnt, 4'b1111, "10-input mix all granted");
    check("R6", gnt_pool, 8'b10_01_00_00, "pool ports lowest-first");

    // R9: four ternary ops
    step(4'b1111, 8'b11_10_01_00, 8'hFF, 8'h00, "R9");
    check("R9", gnt, 4'b0011, "ternary x4 grant");
    check("R7", stall, 4'b1100, "ternary x4 stall");
    check("R7", gnt_pool, 8'b00_00_10_01, "stalled slots no pool");

    // R10: merge pair vs zero-mask pair (add pipe0, fma pipe1)
    step(4'b0011, 8'b00_00_01_00, 8'b00_00_10_01, 8'b00_00_10_10, "R10");
    check("R10", gnt, 4'b0001, "merge pair grant");
    check("R3", stall, 4'b0010, "merge adds an input");
    step(4'b0011, 8'b00_00_01_00, 8'b00_00_10_01, 8'b00_00_01_01, "R10");
    check("R10", gnt, 4'b0011, "zero-mask pair grant");
    check("R3", gnt_pool, 8'b00_00_01_00, "zero mask costs nothing");
    step(4'b0011, 8'b00_00_01_00, 8'b00_00_10_01, 8'b00_00_11_11, "R3");

    // R4/R8: tern p0, fma p0, move p0, move p1
    step(4'b1111, 8'b01_00_00_00, 8'b00_00_10_11, 8'h00, "R4");
    check("R4", stall, 4'b0110, "younger same-pipe stalled");
    check("R8", gnt, 4'b1001, "other pipe proceeds");

    // R5: two moves on one pipe fit the own ports
    step(4'b0011, 8'h00, 8'h00, 8'h00, "R5");
    check("R5", {gnt, gnt_pool}, {4'b0011, 8'h00}, "own ports shared by pipe");
    // R5: add,add on one pipe: second from pool
    step(4'b0011, 8'h00, 8'b00_00_01_01, 8'h00, "R5");
    check("R5", gnt_pool, 8'b00_00_11_00, "remainder from pool");

    // R8: merged tern p0 takes whole pool; add p1 granted; move p0 stalls
    step(4'b0111, 8'b00_00_01_00, 8'b00_00_01_11, 8'b00_00_00_10, "R8");
    check("R8", {gnt, stall}, {4'b0011, 4'b0100}, "pool exhausted");

    for (int n = 0; n < 3000; n++) begin
      step(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R3 R5 R6");
    end

    // R1: asynchronous reset assertion clears at once
    step(4'b1111, 8'b11_10_01_00, 8'h55, 8'h00, "R1");
    #2 rst_n = 1'b0;
    #1 check("R1", {gnt, stall, gnt_pool}, 16'h0, "async reset clears");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(4'b0001, 8'h00, 8'h03, 8'h02, "R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule